// File: doc/BRIEF.md
# POST Code Assembler

The block sits behind the host-side decode of the power-on self-test port. Every byte the host writes there enters a small capture FIFO together with its byte lane, the position the byte held inside the host transaction. A single transaction can deliver up to four bytes, and these arrive as consecutive pushes with lanes 0, 1, 2 and 3. While the local processor holds `drain_en` high, the block pops one entry per clock and ORs each byte into an accumulator at bit position 8 × lane.

A code is complete in either of two cases: the entry after the one just popped has lane 0, or no entry remains behind it. When a code completes, the block presents it for one cycle on `code_valid` with `code_data`. It also reports the number of byte lanes the code spans on `code_len`, and it clears the accumulator. For the local processor the block keeps two sticky flags. `overflow` records a push that was refused. `pending` records any host write and serves as the interrupt request. Each flag is cleared by a write-one-to-clear strobe.

Top module: `post_code_assembler`

## Requirements
- R1: The byte of a popped entry is ORed into the code under assembly at bits [8*lane+7 : 8*lane], where lane is the entry's 2-bit lane field (`push_ofs`, range 0 to 3).
- R2: When the entry that remains at the head after a pop has lane 0, the code is emitted one cycle after that pop, with `code_valid` high for that one cycle. The next code then starts from zero.
- R3: A pop that leaves no older entry behind it completes the code. Pushes made in the same cycle as that pop do not count as a following entry.
- R4: While `drain_en` is high and the FIFO is not empty, exactly one entry is popped per clock. While `drain_en` is low nothing is popped and `code_valid` stays low.
- R5: The FIFO holds DEPTH entries. A push into a full FIFO drops the incoming byte and leaves the stored entries unchanged, so a later drain yields exactly the DEPTH stored entries.
- R6: `overflow` rises in the cycle after a push into a full FIFO. It stays high until an `ovf_clr` pulse. If a refused push and `ovf_clr` occur in the same cycle, the flag stays set.
- R7: `pending` rises in the cycle after any push, including a refused one. A `pend_clr` pulse clears it. If a push and `pend_clr` occur in the same cycle, the flag stays set.
- R8: `code_len` equals the highest lane number among the bytes of the emitted code, plus one.
- R9: After reset `code_valid`, `code_data`, `code_len`, `overflow` and `pending` are all 0, and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Host wrote one byte to the POST port |
| push_data | input | 8 | Byte written by the host |
| push_ofs | input | 2 | Byte lane of that byte within its transaction |
| drain_en | input | 1 | Local processor permits popping |
| ovf_clr | input | 1 | Write-one-to-clear strobe for `overflow` |
| pend_clr | input | 1 | Write-one-to-clear strobe for `pending` |
| code_valid | output | 1 | One-cycle strobe for a completed code |
| code_data | output | 32 | Completed code |
| code_len | output | 3 | Number of byte lanes the code spans (1 to 4) |
| overflow | output | 1 | Sticky flag: a push was refused |
| pending | output | 1 | Sticky flag and interrupt: host write seen |

## Verification
The bench builds the block with DEPTH = 4 and LANES = 4. With a shallow FIFO, a single four-byte transaction fills it exactly, and one extra push already exercises the refused-push path. Codes that mix lanes, codes that start at a lane other than 0, and a drain racing fresh pushes therefore all occur within a few hundred cycles of directed and random traffic. A behavioural queue model tracks every cycle.

// File: rtl/post_code_assembler.sv
module post_code_assembler #(
  parameter int DEPTH = 16,
  parameter int LANES = 4,
  localparam int OFS_W = $clog2(LANES),
  localparam int CODE_W = 8 * LANES,
  localparam int LEN_W = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [7:0]        push_data,
  input  logic [OFS_W-1:0]  push_ofs,
  input  logic              drain_en,
  input  logic              ovf_clr,
  input  logic              pend_clr,
  output logic              code_valid,
  output logic [CODE_W-1:0] code_data,
  output logic [LEN_W-1:0]  code_len,
  output logic              overflow,
  output logic              pending
);
  // DEPTH must be a power of two, at least 2.
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = OFS_W + 8;

  logic [EW-1:0]     mem [DEPTH];
  logic [AW-1:0]     rd_ptr, wr_ptr;
  logic [CW-1:0]     count;
  logic [CODE_W-1:0] acc, acc_next;
  logic [OFS_W-1:0]  hi, hi_next;

  logic          full, pop, accept, last, close_code;
  logic [EW-1:0] head, nxt;
  logic [OFS_W-1:0] head_ofs;

  assign full     = (count == CW'(DEPTH));
  assign pop      = drain_en && (count != '0);
  assign accept   = push_valid && !full;
  assign head     = mem[rd_ptr];
  assign nxt      = mem[rd_ptr + AW'(1)];
  assign head_ofs = head[EW-1:8];
  assign last     = (count == CW'(1));
  assign close_code = pop && (last || nxt[EW-1:8] == '0);
  assign acc_next = acc | (CODE_W'(head[7:0]) << (8 * head_ofs));
  assign hi_next  = (head_ofs > hi) ? head_ofs : hi;

  always_ff @(posedge clk)
    if (accept) mem[wr_ptr] <= {push_ofs, push_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (accept) wr_ptr <= wr_ptr + AW'(1);
      if (pop)    rd_ptr <= rd_ptr + AW'(1);
      count <= count + CW'(accept) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc        <= '0;
      hi         <= '0;
      code_valid <= 1'b0;
      code_data  <= '0;
      code_len   <= '0;
    end else begin
      code_valid <= close_code;
      if (close_code) begin
        code_data <= acc_next;
        code_len  <= LEN_W'(hi_next) + LEN_W'(1);
        acc       <= '0;
        hi        <= '0;
      end else if (pop) begin
        acc <= acc_next;
        hi  <= hi_next;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      overflow <= 1'b0;
      pending  <= 1'b0;
    end else begin
      overflow <= (push_valid && full) || (overflow && !ovf_clr);
      pending  <= push_valid || (pending && !pend_clr);
    end
  end

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_full_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && full && !drain_en |=> count == CW'(DEPTH));
  assert_refused_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && full |=> overflow);
  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !ovf_clr |=> overflow);
  assert_pending_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |=> pending);
  assert_hold_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !drain_en |=> !code_valid);
  assert_emit_needs_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |-> $past(pop));
  assert_len_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |-> (code_len >= LEN_W'(1) && code_len <= LEN_W'(LANES)));
endmodule

// File: tb/tb_post_code_assembler.sv
module tb_post_code_assembler;
  localparam int DEPTH = 4;
  localparam int LANES = 4;

  logic clk = 0, rst_n = 0;
  logic push_valid = 0, drain_en = 0, ovf_clr = 0, pend_clr = 0;
  logic [7:0] push_data = 0;
  logic [1:0] push_ofs = 0;
  logic code_valid, overflow, pending;
  logic [31:0] code_data;
  logic [2:0] code_len;

  post_code_assembler #(.DEPTH(DEPTH), .LANES(LANES)) dut (
    .clk, .rst_n, .push_valid, .push_data, .push_ofs, .drain_en,
    .ovf_clr, .pend_clr, .code_valid, .code_data, .code_len,
    .overflow, .pending);

  always #4 clk = ~clk;

  int checks = 0, errors = 0, codes_seen = 0;
  logic [9:0] q[$];
  logic [31:0] m_acc = 0, e_data = 0;
  int m_hi = 0, e_len = 0;
  bit e_valid = 0, e_ovf = 0, e_pend = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q = {}; m_acc = 0; m_hi = 0; e_valid = 0; e_data = 0; e_len = 0;
      e_ovf = 0; e_pend = 0;
    end else begin
      bit was_full;
      was_full = (q.size() == DEPTH);
      e_valid = 0;
      if (drain_en && q.size() > 0) begin
        logic [9:0] h;
        bit cl;
        h = q[0];
        m_acc = m_acc | (32'(h[7:0]) << (8 * int'(h[9:8])));
        if (int'(h[9:8]) > m_hi) m_hi = int'(h[9:8]);
        cl = (q.size() == 1) || (q[1][9:8] == 2'd0);
        void'(q.pop_front());
        if (cl) begin
          e_valid = 1; e_data = m_acc; e_len = m_hi + 1; m_acc = 0; m_hi = 0;
        end
      end
      if (ovf_clr) e_ovf = 0;
      if (pend_clr) e_pend = 0;
      if (push_valid) begin
        e_pend = 1;
        if (was_full) e_ovf = 1;
        else q.push_back({push_ofs, push_data});
      end
    end
  end

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cmp("R2 code_valid", 32'(code_valid), 32'(e_valid));
    if (e_valid) begin
      cmp("R1 code_data", code_data, e_data);
      cmp("R8 code_len", 32'(code_len), 32'(e_len));
      codes_seen++;
    end
    cmp("R6 overflow", 32'(overflow), 32'(e_ovf));
    cmp("R7 pending", 32'(pending), 32'(e_pend));
    push_valid = 0; ovf_clr = 0; pend_clr = 0;
  endtask

  task automatic push(logic [7:0] d, logic [1:0] o);
    push_valid = 1; push_data = d; push_ofs = o;
    tick();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    int base;
    tick();
    // R9 reset state
    cmp("R9 reset valid", 32'(code_valid), 0);
    cmp("R9 reset data", code_data, 0);
    cmp("R9 reset len", 32'(code_len), 0);
    cmp("R9 reset flags", {30'b0, overflow, pending}, 0);
    rst_n = 1;
    idle(2);

    // four-lane code while held, R4: nothing emitted during hold
    base = codes_seen;
    push(8'h11, 0); push(8'h22, 1); push(8'h33, 2); push(8'h44, 3);
    idle(3);
    cmp("R4 held no pop", 32'(codes_seen - base), 0);
    drain_en = 1; idle(6);
    cmp("R4 one code from four entries", 32'(codes_seen - base), 1);

    // R3 single bytes with gaps, drain running
    base = codes_seen;
    push(8'hA5, 0); idle(2); push(8'h5A, 0); idle(2);
    cmp("R3 dry drain closes each", 32'(codes_seen - base), 2);

    // R2 boundary on lane 0, R8 length with gap lane
    drain_en = 0;
    push(8'hAA, 0); push(8'hBB, 1); push(8'hCC, 0); push(8'hDD, 2);
    drain_en = 1; idle(6);

    // code not starting at lane 0
    push(8'h05, 2); idle(3);

    // R5/R6 overflow: five pushes into four slots
    drain_en = 0;
    for (int i = 0; i < 5; i++) push(8'(8'h60 + i), 0);
    cmp("R6 overflow set", 32'(overflow), 1);
    base = codes_seen;
    drain_en = 1; idle(6);
    cmp("R5 kept entries", 32'(codes_seen - base), DEPTH);
    ovf_clr = 1; tick();
    cmp("R6 overflow cleared", 32'(overflow), 0);
    pend_clr = 1; tick();
    cmp("R7 pending cleared", 32'(pending), 0);

    // R6/R7 set wins over clear
    drain_en = 0;
    for (int i = 0; i < 4; i++) push(8'(i), 0);
    ovf_clr = 1; pend_clr = 1; push(8'hEE, 1);
    cmp("R6 set beats clear", 32'(overflow), 1);
    cmp("R7 set beats clear", 32'(pending), 1);
    drain_en = 1; idle(6);

    // random traffic, model compared every cycle
    for (int i = 0; i < 600; i++) begin
      push_valid = ($urandom_range(0, 2) != 0);
      push_data = 8'($urandom);
      push_ofs = 2'($urandom);
      drain_en = ($urandom_range(0, 3) != 0);
      ovf_clr = ($urandom_range(0, 15) == 0);
      pend_clr = ($urandom_range(0, 7) == 0);
      @(negedge clk);
      cmp("R2 code_valid", 32'(code_valid), 32'(e_valid));
      if (e_valid) begin
        cmp("R1 code_data", code_data, e_data);
        cmp("R8 code_len", 32'(code_len), 32'(e_len));
      end
      cmp("R6 overflow", 32'(overflow), 32'(e_ovf));
      cmp("R7 pending", 32'(pending), 32'(e_pend));
    end
    push_valid = 0; ovf_clr = 0; pend_clr = 0; drain_en = 1;
    idle(8);
    finish_run();
  end
endmodule